// File: doc/BRIEF.md
# Broadcast March Self-Test with Per-Memory Verdicts

This block runs a March C- self-test on several synchronous RAMs at the same time. One sequencer produces the address, the write word and the read/write strobes for every step. It drives these values to all memories at once, together with a small step tag that names the current March element and the operation inside it. Next to each memory sits its own checker. The checker rebuilds the expected read word from the step tag, compares it with that memory's read port one cycle after the read, and keeps a sticky failure flag. A single run therefore gives a separate pass or fail result for every memory.

The memories are behavioural models of 2^ADDR_W words of DATA_W bits. A parameter can place a stuck-at cell in one of them. A pulse on `start` launches a run. `done` rises once the last comparison has been made and holds, with the flags frozen, until the next accepted start. Fault repair and spare allocation are left to other logic.

Top module: `march_mbist_array`

## Requirements
- R1: After reset, `done` and `busy` are 0, `fail` is all zeros, and neither `bus_we` nor `bus_re` is asserted.
- R2: A high `start` is accepted only when the sequencer is idle or done. A `start` seen while `busy` is 1 has no effect on the sequence or on its completion time.
- R3: Each bus cycle carries exactly one operation, in this order of six elements: write 0; read 0 then write 1; read 1 then write 0; read 0 then write 1; read 1 then write 0; read 0. Both operations of an element are applied to one address before the address moves on. A write of polarity p drives every bit of `bus_wdata` to p.
- R4: Elements 0, 1, 2 and 5 step the address upward from 0 to 2^ADDR_W-1. Elements 3 and 4 step it downward from 2^ADDR_W-1 to 0.
- R5: `bus_we` and `bus_re` are never high together, and both stay low whenever `busy` is 0.
- R6: `done` rises exactly 10*2^ADDR_W+1 clock edges after the edge that accepts `start`. It then stays high until the next accepted start.
- R7: Each checker compares its memory's read word with the expected all-zeros or all-ones word one cycle after each read, and only after reads. Any mismatch sets its `fail` bit, and the bit stays set for the rest of the run.
- R8: At `done`, the `fail` bit of a fault-free memory is 0, and the `fail` bit of a memory with one stuck-at cell is 1.
- R9: All `fail` bits read 0 on the cycle after an accepted start. While `done` is high and no start is given, `fail` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, accepted while idle or done |
| busy | output | 1 | High while operations or the final compare are pending |
| done | output | 1 | High after the run completes, until the next start |
| bus_addr | output | ADDR_W | Broadcast address |
| bus_we | output | 1 | Broadcast write strobe |
| bus_re | output | 1 | Broadcast read strobe |
| bus_wdata | output | DATA_W | Broadcast write word |
| fail | output | N_MEM | Sticky per-memory failure flags |

## Verification
The bench follows the whole run cycle by cycle against an element table of its own. This catches a sequencer that turns around at the wrong end of the address range, skips the second operation of an element, or writes the wrong polarity. It places a stuck-at-1 cell in one memory and leaves the other clean. A checker that compared on the read cycle itself, or one that compared after writes, would flag the clean memory or miss the faulty one. It also checks the following:
- `done` must not rise before the last read has been compared, so an early `done` is caught.
- A second `start` pulse in the middle of a run must not restart the sequence.
- The flags must clear on relaunch and must hold steady while `done` is high.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

   localparam int unsigned N_ELEM = 6;
   localparam int unsigned ELEM_W = 3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_DONE  = 2'd3
   } seq_state_e;

   // Per-element description of the March C- algorithm
   typedef struct packed {
      logic down;      // address runs high to low
      logic two_ops;   // element holds a second operation
      logic first_rd;  // first operation is a read
      logic pol0;      // data polarity of first operation
      logic pol1;      // data polarity of second operation
   } elem_t;

   function automatic elem_t elem_info(input logic [ELEM_W-1:0] e);
      elem_t r;
      case (e)
         3'd0:    r = '{down:1'b0, two_ops:1'b0, first_rd:1'b0, pol0:1'b0, pol1:1'b0};
         3'd1:    r = '{down:1'b0, two_ops:1'b1, first_rd:1'b1, pol0:1'b0, pol1:1'b1};
         3'd2:    r = '{down:1'b0, two_ops:1'b1, first_rd:1'b1, pol0:1'b1, pol1:1'b0};
         3'd3:    r = '{down:1'b1, two_ops:1'b1, first_rd:1'b1, pol0:1'b0, pol1:1'b1};
         3'd4:    r = '{down:1'b1, two_ops:1'b1, first_rd:1'b1, pol0:1'b1, pol1:1'b0};
         default: r = '{down:1'b0, two_ops:1'b0, first_rd:1'b1, pol0:1'b0, pol1:1'b0};
      endcase
      return r;
   endfunction

   function automatic logic step_pol(input logic [ELEM_W-1:0] e, input logic op);
      elem_t r;
      r = elem_info(e);
      return op ? r.pol1 : r.pol0;
   endfunction

endpackage

// File: rtl/mbist_march_ctrl.sv
module mbist_march_ctrl
   import mbist_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              launch,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] addr,
   output logic              we,
   output logic              re,
   output logic [DATA_W-1:0] wdata,
   output logic [ELEM_W-1:0] step_elem,
   output logic              step_op
);

   localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(N_ELEM - 1);
   localparam logic [ADDR_W-1:0] ADDR_TOP  = '1;
   localparam logic [ADDR_W-1:0] ADDR_BOT  = '0;

   seq_state_e        state_q;
   logic [ELEM_W-1:0] elem_q;
   logic              op_q;
   logic [ADDR_W-1:0] addr_q;

   elem_t             cur;
   elem_t             nxt;
   logic              running;
   logic              is_read;
   logic              pol;
   logic              op_last;
   logic              addr_end;

   always_comb begin
      cur      = elem_info(elem_q);
      nxt      = elem_info(elem_q + 1'b1);
      running  = (state_q == ST_RUN);
      is_read  = cur.first_rd && !op_q;
      pol      = op_q ? cur.pol1 : cur.pol0;
      op_last  = !cur.two_ops || op_q;
      addr_end = cur.down ? (addr_q == ADDR_BOT) : (addr_q == ADDR_TOP);
      launch   = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         elem_q  <= '0;
         op_q    <= 1'b0;
         addr_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE, ST_DONE: begin
               if (launch) begin
                  state_q <= ST_RUN;
                  elem_q  <= '0;
                  op_q    <= 1'b0;
                  addr_q  <= ADDR_BOT;
               end
            end
            ST_RUN: begin
               if (!op_last) begin
                  op_q <= 1'b1;
               end else begin
                  op_q <= 1'b0;
                  if (!addr_end) begin
                     addr_q <= cur.down ? addr_q - 1'b1 : addr_q + 1'b1;
                  end else if (elem_q == LAST_ELEM) begin
                     state_q <= ST_DRAIN;
                  end else begin
                     elem_q <= elem_q + 1'b1;
                     addr_q <= nxt.down ? ADDR_TOP : ADDR_BOT;
                  end
               end
            end
            default: state_q <= ST_DONE;
         endcase
      end
   end

   assign busy      = running || (state_q == ST_DRAIN);
   assign done      = (state_q == ST_DONE);
   assign addr      = addr_q;
   assign we        = running && !is_read;
   assign re        = running && is_read;
   assign wdata     = {DATA_W{pol}};
   assign step_elem = elem_q;
   assign step_op   = op_q;

endmodule

// File: rtl/mbist_sim_ram.sv
module mbist_sim_ram #(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 8,
   parameter bit          STUCK_EN   = 1'b0,
   parameter int unsigned STUCK_ADDR = 0,
   parameter int unsigned STUCK_BIT  = 0,
   parameter bit          STUCK_VAL  = 1'b0
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              re,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rd_word;

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   generate
      if (STUCK_EN) begin : g_stuck
         always_comb begin
            rd_word = mem[addr];
            if (addr == ADDR_W'(STUCK_ADDR)) rd_word[STUCK_BIT] = STUCK_VAL;
         end
      end else begin : g_clean
         always_comb rd_word = mem[addr];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (re) rdata <= rd_word;
   end

endmodule

// File: rtl/mbist_local_chk.sv
module mbist_local_chk
   import mbist_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              rd_en,
   input  logic [ELEM_W-1:0] step_elem,
   input  logic              step_op,
   input  logic [DATA_W-1:0] rdata,
   output logic              fail
);

   logic              rd_q;
   logic [DATA_W-1:0] exp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= 1'b0;
         exp_q <= '0;
         fail  <= 1'b0;
      end else begin
         rd_q  <= rd_en;
         exp_q <= {DATA_W{step_pol(step_elem, step_op)}};
         if (clear)                         fail <= 1'b0;
         else if (rd_q && (rdata != exp_q)) fail <= 1'b1;
      end
   end

endmodule

// File: rtl/march_mbist_array.sv
module march_mbist_array
   import mbist_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned N_MEM      = 2,
   parameter bit          FAULT_EN   = 1'b0,
   parameter int unsigned FAULT_MEM  = 0,
   parameter int unsigned FAULT_ADDR = 0,
   parameter int unsigned FAULT_BIT  = 0,
   parameter bit          FAULT_VAL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_we,
   output logic              bus_re,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [N_MEM-1:0]  fail
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
      if (N_MEM < 1) begin : g_bad_nmem
         $error("N_MEM must be positive");
      end
      if (FAULT_EN && (FAULT_MEM >= N_MEM || FAULT_ADDR >= DEPTH || FAULT_BIT >= DATA_W)) begin : g_bad_fault
         $error("fault location outside the array");
      end
   endgenerate

   logic              launch;
   logic [ELEM_W-1:0] step_elem;
   logic              step_op;

   mbist_march_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .launch    (launch),
      .busy      (busy),
      .done      (done),
      .addr      (bus_addr),
      .we        (bus_we),
      .re        (bus_re),
      .wdata     (bus_wdata),
      .step_elem (step_elem),
      .step_op   (step_op)
   );

   generate
      for (genvar g = 0; g < N_MEM; g++) begin : g_mem
         logic [DATA_W-1:0] rdata;

         mbist_sim_ram #(
            .ADDR_W     (ADDR_W),
            .DATA_W     (DATA_W),
            .STUCK_EN   (FAULT_EN && (g == FAULT_MEM)),
            .STUCK_ADDR (FAULT_ADDR),
            .STUCK_BIT  (FAULT_BIT),
            .STUCK_VAL  (FAULT_VAL)
         ) u_ram (
            .clk   (clk),
            .addr  (bus_addr),
            .we    (bus_we),
            .re    (bus_re),
            .wdata (bus_wdata),
            .rdata (rdata)
         );

         mbist_local_chk #(.DATA_W(DATA_W)) u_chk (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (launch),
            .rd_en     (bus_re),
            .step_elem (step_elem),
            .step_op   (step_op),
            .rdata     (rdata),
            .fail      (fail[g])
         );
      end
   endgenerate

endmodule

// File: rtl/mbist_march_sva.sv
module mbist_march_sva #(
   parameter int unsigned N_MEM = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             launch,
   input logic             busy,
   input logic             done,
   input logic             bus_we,
   input logic             bus_re,
   input logic [N_MEM-1:0] fail
);

   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !bus_we && !bus_re);  // R1

   AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !launch);  // R2

   AST_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_re));  // R5

   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_we && !bus_re);  // R5

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);  // R6

   AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));  // R6

   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !launch |=> ((fail & $past(fail)) == $past(fail)));  // R7

   AST_CLEAR_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (fail == '0));  // R9

   AST_FAIL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> $stable(fail));  // R9

endmodule

bind march_mbist_array mbist_march_sva #(.N_MEM(N_MEM)) u_sva (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .launch (launch),
   .busy   (busy),
   .done   (done),
   .bus_we (bus_we),
   .bus_re (bus_re),
   .fail   (fail)
);

// File: tb/march_mbist_array_tb.sv
module march_mbist_array_tb;

   localparam int AW    = 4;
   localparam int DW    = 8;
   localparam int NM    = 2;
   localparam int DEPTH = 1 << AW;
   localparam int NOPS  = 10 * DEPTH;

   // Element table: {descending, two operations, first is read, polarity 0, polarity 1}
   localparam logic [4:0] ELEMS [6] = '{
      5'b0_0_0_0_0,
      5'b0_1_1_0_1,
      5'b0_1_1_1_0,
      5'b1_1_1_0_1,
      5'b1_1_1_1_0,
      5'b0_0_1_0_0
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          busy, done, bus_we, bus_re;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [NM-1:0] fail;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   march_mbist_array #(
      .ADDR_W(AW), .DATA_W(DW), .N_MEM(NM),
      .FAULT_EN(1'b1), .FAULT_MEM(1), .FAULT_ADDR(5), .FAULT_BIT(3), .FAULT_VAL(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
      .bus_wdata(bus_wdata), .fail(fail)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // Walks the bench's own March model; optionally pulses start at op index pulse_at
   task automatic walk_run(input int pulse_at);
      int k = 0;
      for (int e = 0; e < 6; e++) begin
         for (int s = 0; s < DEPTH; s++) begin
            int a = ELEMS[e][4] ? DEPTH - 1 - s : s;
            int nop = ELEMS[e][3] ? 2 : 1;
            for (int o = 0; o < nop; o++) begin
               bit rd  = (o == 0) && ELEMS[e][2];
               bit pol = (o == 0) ? ELEMS[e][1] : ELEMS[e][0];
               chk("R4", "address", 32'(bus_addr), 32'(a));
               chk("R3", "read strobe", 32'(bus_re), 32'(rd));
               chk("R3", "write strobe", 32'(bus_we), 32'(!rd));
               if (!rd) chk("R3", "write word", 32'(bus_wdata), 32'({DW{pol}}));
               start = (k == pulse_at);  // R2: start during busy must be ignored
               tick();
               start = 1'b0;
               k++;
            end
         end
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R6 watchdog expired: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      // R1: reset state
      chk("R1", "done", 32'(done), 0);
      chk("R1", "busy", 32'(busy), 0);
      chk("R1", "fail", 32'(fail), 0);
      chk("R1", "strobes", 32'({bus_we, bus_re}), 0);
      rst_n = 1'b1;
      tick();
      chk("R5", "idle strobes", 32'({bus_we, bus_re}), 0);

      // First run, with the bench's element table walked op by op
      start = 1'b1;
      tick();
      start = 1'b0;
      chk("R2", "busy after start", 32'(busy), 1);
      walk_run(-1);
      chk("R6", "done before final compare", 32'(done), 0);
      tick();
      chk("R6", "done at 10N+1", 32'(done), 1);
      chk("R8", "clean ram flag", 32'(fail[0]), 0);
      chk("R8", "stuck ram flag", 32'(fail[1]), 1);

      // R9: flags frozen while done is held
      repeat (15) tick();
      chk("R6", "done held", 32'(done), 1);
      chk("R9", "flags frozen", 32'(fail), 32'(2'b10));
      chk("R5", "quiet when done", 32'({bus_we, bus_re}), 0);

      // Second run, with a start pulse in mid-run (R2)
      start = 1'b1;
      tick();
      start = 1'b0;
      chk("R9", "flags cleared on launch", 32'(fail), 0);
      walk_run(57);
      chk("R2", "no done after mid-run start", 32'(done), 0);
      tick();
      chk("R2", "done timing unchanged", 32'(done), 1);
      chk("R7", "clean ram stays clear", 32'(fail[0]), 0);
      chk("R7", "stuck ram caught again", 32'(fail[1]), 1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule